// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small processor core and decides when, and to which handler, the core is diverted. It gathers two kinds of requests. Latched sources set a sticky pending flag on a one-cycle event. Level sources request service only while their condition input is held high. Each source has its own enable, and a global enable gates all of them. When several enabled requests are pending, the one with the lowest index wins.

Entry and return run as fixed-length hardware sequences. Entry is allowed only at an instruction boundary, or at once while the core sleeps. It saves the return address as three bytes on a downward-growing stack, clears the global enable, clears the served latched flag and presents the handler's vector address. The return sequence pops the three bytes, gives back the address and sets the global enable again. The core is represented by event inputs: an instruction completed, and whether that instruction was a disable, an enable or a return-from-handler. A base-select input moves the whole vector table to an alternate base.

Top module: `vpic_ctrl`

## Requirements
- R1: Among the pending enabled requests, the lowest index is served. Its vector address is base + 2*(index+1). The base is 0 when `vec_base_sel` is 0 and ALT_BASE (default 16'h0F00) when it is 1. Slot 0 is left for reset.
- R2: A latched source's flag (bit i of `flags`) is set by a pulse on `src_evt[i]` whatever its enable. It stays set until it is served or cleared. If a set and a clear fall in the same cycle, the set wins.
- R3: Writing with `flag_clr_wr` high clears every latched flag whose bit is 1 in `flag_clr_data`. Taking a latched source's handler clears that source's flag in the same cycle.
- R4: The sources in LEVEL_MASK (default bits 7 and 6) never set a flag. They request only while `src_lvl[i]` and `src_en[i]` are both high, so a level that goes away before it is enabled is never served.
- R5: A handler is entered only when `insn_retire` is high with the global enable set and some request pending. The cycle after entry, `gie` is 0. Entry takes 5 cycles. The address is pushed low byte first on cycles 2 to 4, `sp` drops by 3, and `vec_valid` is high on cycle 5.
- R6: If `cpu_asleep` is high, the handler is entered without a completed instruction, and entry takes 10 cycles in total.
- R7: A completed instruction with `insn_reti` starts a 5-cycle return. It pops 3 bytes (high byte first) on cycles 2 to 4 and shows the restored address on `ret_addr` with `ret_valid` on cycle 5. After it, `sp` is 3 higher and `gie` is 1.
- R8: After a return and after an enable instruction, exactly one more instruction completes before a pending request is entered.
- R9: A disable instruction acts in its own cycle. No handler is entered at its completion, even with a request already pending.
- R10: After reset, `gie` is 0, `flags` is 0, `sp` is SP_INIT (default 16'h21FF), and there is no push, pop or vector strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | NUM_SRC | Event pulses for latched sources |
| src_lvl | input | NUM_SRC | Conditions for level sources |
| src_en | input | NUM_SRC | Per-source enables |
| flag_clr_wr | input | 1 | Write strobe for clearing flags |
| flag_clr_data | input | NUM_SRC | Ones mark the flags to clear |
| insn_retire | input | 1 | An instruction completed this cycle |
| insn_cli | input | 1 | The completing instruction disables interrupts |
| insn_sei | input | 1 | The completing instruction enables interrupts |
| insn_reti | input | 1 | The completing instruction returns from a handler |
| cpu_asleep | input | 1 | Core is sleeping |
| vec_base_sel | input | 1 | Selects the alternate vector base |
| ret_addr_in | input | PC_W | Address to resume at after the handler |
| gie | output | 1 | Global enable |
| flags | output | NUM_SRC | Latched pending flags |
| push_en | output | 1 | Stack write strobe |
| push_byte | output | 8 | Byte written to the stack at `sp` |
| pop_en | output | 1 | Stack read strobe |
| pop_byte | input | 8 | Byte read from the stack at `sp`+1 |
| sp | output | SP_W | Stack pointer |
| vec_valid | output | 1 | Vector address valid |
| vec_addr | output | VEC_W | Handler vector address in words |
| ret_valid | output | 1 | Restored address valid |
| ret_addr | output | PC_W | Restored return address |

## Verification
Random mixes of events, held levels, enables and base selects are followed by an enable and a completed instruction. The vector taken is compared with the lowest pending enabled index, or with no entry when nothing qualifies. This tells priority apart from enable gating and from the latched/level split. A long stretch with interrupts disabled applies random events and write-one-to-clear writes at the same time, to separate set-wins from clear-wins. Directed runs enter while awake and while asleep. They hold a request through enable, disable and return instructions, and they pulse a level before it is enabled, which separates the one-instruction grace periods and immediate disable from off-by-one timing.

// File: rtl/vpic_pkg.sv
// Shared types for the interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package vpic_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_RET   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/vpic_flags.sv
// Latched pending flags, one per non-level source.
// Assumes: a served source index is only presented with srv_valid high.
module vpic_flags #(
    parameter int          NUM_SRC    = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0,
    localparam int         IDX_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_wr,
    input  logic [NUM_SRC-1:0] clr_data,
    input  logic               srv_valid,
    input  logic [IDX_W-1:0]   srv_idx,
    output logic [NUM_SRC-1:0] flags_q
);
    logic [NUM_SRC-1:0] drop_v;

    // Combine software clear and hardware service clear.
    always_comb begin
        drop_v = clr_wr ? clr_data : '0;
        if (srv_valid) drop_v[srv_idx] = 1'b1;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        if (LEVEL_MASK[i]) begin : g_level
            assign flags_q[i] = 1'b0;
        end else begin : g_latch
            // Sticky flag: an event sets it, a clear drops it, and the set wins.
            always_ff @(posedge clk) begin
                if (!rst_n)         flags_q[i] <= 1'b0;
                else if (evt[i])    flags_q[i] <= 1'b1;
                else if (drop_v[i]) flags_q[i] <= 1'b0;
            end
        end
    end

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~drop_v) != '0) |=>
        ((flags_q & $past(flags_q & ~drop_v)) == $past(flags_q & ~drop_v)));

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & ~LEVEL_MASK) != '0) |=>
        ((flags_q & $past(evt & ~LEVEL_MASK)) == $past(evt & ~LEVEL_MASK)));
endmodule

// File: rtl/vpic_arbiter.sv
// Fixed-priority picker: the lowest set request index wins.
// Assumes: req is already masked by the per-source enables.
module vpic_arbiter #(
    parameter int  NUM_SRC = 8,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);
    // Scan from high to low, so the lowest index is written last and wins.
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assert_grant_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> req[idx]);

    assert_no_lower_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((req & ((NUM_SRC'(1) << idx) - NUM_SRC'(1))) == '0));
endmodule

// File: rtl/vpic_seq.sv
// Entry and return sequencer. It owns the global enable, the stack pointer,
// the byte push/pop handshake and the vector address.
// Assumes: cli/sei/reti are qualified by retire; the stack is outside the block.
module vpic_seq
    import vpic_pkg::*;
#(
    parameter int               NUM_SRC  = 8,
    parameter int               PC_W     = 22,
    parameter int               SP_W     = 16,
    parameter int               VEC_W    = 16,
    parameter int               WAKE_CYC = 5,
    parameter logic [SP_W-1:0]  SP_INIT  = 16'h21FF,
    parameter logic [VEC_W-1:0] ALT_BASE = 16'h0F00,
    localparam int IDX_W     = $clog2(NUM_SRC),
    localparam int NBYTES    = (PC_W + 7) / 8,
    localparam int PCX_W     = 8 * NBYTES,
    localparam int ENTRY_LEN = NBYTES + 2,
    localparam int RET_LEN   = NBYTES + 2,
    localparam int CNT_W     = $clog2(ENTRY_LEN + WAKE_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    input  logic             cli,
    input  logic             sei,
    input  logic             reti,
    input  logic             asleep,
    input  logic             base_sel,
    input  logic [PC_W-1:0]  pc_in,
    input  logic             arb_valid,
    input  logic [IDX_W-1:0] arb_idx,
    input  logic [7:0]       pop_byte,
    output logic             take,
    output logic             gie_q,
    output logic             push_en,
    output logic [7:0]       push_byte,
    output logic             pop_en,
    output logic [SP_W-1:0]  sp_q,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_addr,
    output logic             ret_valid,
    output logic [PC_W-1:0]  ret_addr
);
    seq_state_t       st_q;
    logic [CNT_W-1:0] cnt_q, last_c, pstart, bi;
    logic [IDX_W-1:0] idx_q;
    logic [PCX_W-1:0] pc_q, acc_q, shifted;
    logic             slept_q, base_q;

    // Entry is allowed at an instruction boundary or while sleeping, never on a disable.
    assign take = (st_q == ST_RUN) && gie_q && arb_valid && !(retire && cli)
                  && (retire || asleep);

    // Work out the entry length and the push window.
    always_comb begin
        last_c  = slept_q ? CNT_W'(ENTRY_LEN + WAKE_CYC - 1) : CNT_W'(ENTRY_LEN - 1);
        pstart  = last_c - CNT_W'(NBYTES);
        bi      = cnt_q - pstart;
        shifted = pc_q >> (8 * bi);
    end

    assign push_en   = (st_q == ST_ENTER) && (cnt_q >= pstart) && (cnt_q < last_c);
    assign push_byte = shifted[7:0];
    assign vec_valid = (st_q == ST_ENTER) && (cnt_q == last_c);
    assign vec_addr  = (base_q ? ALT_BASE : '0) + VEC_W'((32'(idx_q) + 1) * 2);
    assign pop_en    = (st_q == ST_RET) && (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(NBYTES));
    assign ret_valid = (st_q == ST_RET) && (cnt_q == CNT_W'(RET_LEN - 1));
    assign ret_addr  = acc_q[PC_W-1:0];

    // State, counter, global enable, stack pointer and popped address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_RUN;
            cnt_q   <= '0;
            gie_q   <= 1'b0;
            sp_q    <= SP_INIT;
            idx_q   <= '0;
            pc_q    <= '0;
            acc_q   <= '0;
            slept_q <= 1'b0;
            base_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_RUN: begin
                    cnt_q <= '0;
                    if (take) begin
                        st_q    <= ST_ENTER;
                        gie_q   <= 1'b0;
                        idx_q   <= arb_idx;
                        pc_q    <= PCX_W'(pc_in);
                        slept_q <= asleep && !retire;
                        base_q  <= base_sel;
                    end else if (retire && reti) begin
                        st_q <= ST_RET;
                    end else if (retire && cli) begin
                        gie_q <= 1'b0;
                    end else if (retire && sei) begin
                        gie_q <= 1'b1;
                    end
                end
                ST_ENTER: begin
                    if (push_en) sp_q <= sp_q - SP_W'(1);
                    if (cnt_q == last_c) st_q <= ST_RUN;
                    else                 cnt_q <= cnt_q + CNT_W'(1);
                end
                ST_RET: begin
                    if (pop_en) begin
                        sp_q  <= sp_q + SP_W'(1);
                        acc_q <= (acc_q << 8) | PCX_W'(pop_byte);
                    end
                    if (ret_valid) begin
                        st_q  <= ST_RUN;
                        gie_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end

    assert_gie_off_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!gie_q && st_q == ST_ENTER));

    assert_cli_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && retire && cli) |=> (st_q != ST_ENTER));

    assert_gie_after_ret_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (gie_q && st_q == ST_RUN));

    assert_sei_grace_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !gie_q && retire && sei) |=> (st_q == ST_RUN));
endmodule

// File: rtl/vpic_ctrl.sv
// Top of the vectored priority interrupt controller: the flags, the request
// masking, the arbiter and the entry/return sequencer.
// Assumes: the core holds off issuing instructions while entry or return runs.
module vpic_ctrl #(
    parameter int                 NUM_SRC    = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0,
    parameter int                 PC_W       = 22,
    parameter int                 SP_W       = 16,
    parameter int                 VEC_W      = 16,
    parameter int                 WAKE_CYC   = 5,
    parameter logic [SP_W-1:0]    SP_INIT    = 16'h21FF,
    parameter logic [VEC_W-1:0]   ALT_BASE   = 16'h0F00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               flag_clr_wr,
    input  logic [NUM_SRC-1:0] flag_clr_data,
    input  logic               insn_retire,
    input  logic               insn_cli,
    input  logic               insn_sei,
    input  logic               insn_reti,
    input  logic               cpu_asleep,
    input  logic               vec_base_sel,
    input  logic [PC_W-1:0]    ret_addr_in,
    output logic               gie,
    output logic [NUM_SRC-1:0] flags,
    output logic               push_en,
    output logic [7:0]         push_byte,
    output logic               pop_en,
    input  logic [7:0]         pop_byte,
    output logic [SP_W-1:0]    sp,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_addr,
    output logic               ret_valid,
    output logic [PC_W-1:0]    ret_addr
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] req;
    logic               arb_valid, take;
    logic [IDX_W-1:0]   arb_idx;

    vpic_flags #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) flags_i (
        .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr_wr(flag_clr_wr),
        .clr_data(flag_clr_data), .srv_valid(take), .srv_idx(arb_idx), .flags_q(flags)
    );

    // Pending latched flags plus live level conditions, both gated by the enables.
    assign req = src_en & (flags | (src_lvl & LEVEL_MASK));

    vpic_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
        .clk(clk), .rst_n(rst_n), .req(req), .valid(arb_valid), .idx(arb_idx)
    );

    vpic_seq #(
        .NUM_SRC(NUM_SRC), .PC_W(PC_W), .SP_W(SP_W), .VEC_W(VEC_W),
        .WAKE_CYC(WAKE_CYC), .SP_INIT(SP_INIT), .ALT_BASE(ALT_BASE)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .retire(insn_retire), .cli(insn_cli),
        .sei(insn_sei), .reti(insn_reti), .asleep(cpu_asleep), .base_sel(vec_base_sel),
        .pc_in(ret_addr_in), .arb_valid(arb_valid), .arb_idx(arb_idx),
        .pop_byte(pop_byte), .take(take), .gie_q(gie), .push_en(push_en),
        .push_byte(push_byte), .pop_en(pop_en), .sp_q(sp), .vec_valid(vec_valid),
        .vec_addr(vec_addr), .ret_valid(ret_valid), .ret_addr(ret_addr)
    );

    assert_level_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & LEVEL_MASK) == '0));
endmodule

// File: tb/vpic_ctrl_tb_top.sv
// Self-checking bench for vpic_ctrl: a seeded random mix plus directed corners.
module vpic_ctrl_tb_top;
    localparam int N = 8;
    localparam logic [7:0] LVL = 8'hC0;
    localparam logic [15:0] SP0 = 16'h21FF;
    localparam logic [15:0] ALT = 16'h0F00;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] src_evt = '0, src_lvl = '0, src_en = '0, flag_clr_data = '0;
    logic flag_clr_wr = 0, insn_retire = 0, insn_cli = 0, insn_sei = 0, insn_reti = 0;
    logic cpu_asleep = 0, vec_base_sel = 0;
    logic [21:0] ret_addr_in = '0;
    logic gie, push_en, pop_en, vec_valid, ret_valid;
    logic [N-1:0] flags;
    logic [7:0] push_byte, pop_byte;
    logic [15:0] sp, vec_addr;
    logic [21:0] ret_addr;
    logic [7:0] mem [0:255];
    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    vpic_ctrl dut_i (.*);

    // Stack model outside the block.
    always @(posedge clk) if (push_en) mem[sp[7:0]] <= push_byte;
    assign pop_byte = mem[8'(sp + 16'd1)];

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = N - 1; i >= 0; i--) if (r[i]) lowest = i;
        if (r == '0) lowest = -1;
    endfunction

    // One completed instruction with optional cli/sei/reti.
    task automatic insn(input logic c, input logic s, input logic r);
        insn_retire = 1; insn_cli = c; insn_sei = s; insn_reti = r;
        tick();
        insn_retire = 0; insn_cli = 0; insn_sei = 0; insn_reti = 0;
    endtask

    // Watch an entry that started at the last edge; check length, bytes, vector.
    task automatic watch_entry(input string req, input int exp_len, input logic [15:0] exp_vec);
        logic [23:0] got = '0; int np = 0, len = 0; logic [15:0] sp0 = sp; logic [15:0] v = '0;
        chk(gie == 1'b0, "R5 gie cleared on entry", 64'(gie), 0);
        for (int k = 1; k <= 20; k++) begin
            if (push_en) begin got = got | (24'(push_byte) << (8 * np)); np++; end
            if (vec_valid) begin len = k; v = vec_addr; break; end
            tick();
        end
        chk(len == exp_len, req, 64'(len), 64'(exp_len));
        chk(v == exp_vec, "R1 vector address", 64'(v), 64'(exp_vec));
        chk(got == 24'(ret_addr_in) && np == 3, "R5 pushed bytes", 64'(got), 64'(ret_addr_in));
        tick();
        chk(sp == sp0 - 16'd3, "R5 sp after entry", 64'(sp), 64'(sp0 - 16'd3));
    endtask

    // Return from a handler and check the popped address.
    task automatic do_return(input logic [21:0] exp_pc);
        int len = 0; logic [15:0] sp0 = sp; logic [21:0] a = '0;
        insn(0, 0, 1);
        for (int k = 1; k <= 10; k++) begin
            if (ret_valid) begin len = k; a = ret_addr; break; end
            tick();
        end
        chk(len == 5, "R7 return length", 64'(len), 5);
        chk(a == exp_pc, "R7 restored address", 64'(a), 64'(exp_pc));
        tick();
        chk(gie == 1'b1 && sp == sp0 + 16'd3, "R7 gie and sp after return", {gie, sp}, {1'b1, sp0 + 16'd3});
    endtask

    // True if no entry shows within n cycles.
    task automatic quiet(input string req, input int n);
        logic seen = 0;
        for (int k = 0; k < n; k++) begin if (push_en || vec_valid) seen = 1; tick(); end
        chk(!seen, req, 64'(seen), 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] exp_f, ev, cl, en, lv, rq;
        logic cw;
        int e, seed;
        seed = $urandom(32'h5EED1234);
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R10 reset state
        chk(gie == 0 && flags == 0 && sp == SP0 && !push_en && !pop_en && !vec_valid,
            "R10 reset state", {gie, flags, sp}, {1'b0, 8'h00, SP0});

        // R2/R3/R4: random events and clears with interrupts disabled.
        exp_f = '0;
        for (int t = 0; t < 300; t++) begin
            ev = 8'($urandom); cl = 8'($urandom); cw = 1'($urandom);
            if (t % 3 != 0) ev = ev & 8'($urandom);
            src_evt = ev; flag_clr_wr = cw; flag_clr_data = cl; src_en = 8'($urandom);
            src_lvl = 8'($urandom);
            tick();
            exp_f = (exp_f & ~(cw ? cl : 8'h00)) | (ev & ~LVL);
            chk(flags == exp_f, "R2 R3 R4 flag update", 64'(flags), 64'(exp_f));
        end
        src_evt = '0; flag_clr_wr = 0; src_lvl = '0; src_en = '0;

        // R1/R3/R4/R5: random pending mixes, one entry each.
        for (int t = 0; t < 40; t++) begin
            insn(1, 0, 0);
            flag_clr_wr = 1; flag_clr_data = '1; tick(); flag_clr_wr = 0;
            ev = 8'($urandom); en = 8'($urandom); lv = 8'($urandom);
            if (t % 4 == 0) en = '0;
            src_evt = ev; tick(); src_evt = '0;
            src_en = en; src_lvl = lv; vec_base_sel = 1'($urandom);
            ret_addr_in = 22'($urandom);
            rq = en & ((ev & ~LVL) | (lv & LVL));
            e = lowest(rq);
            insn(0, 1, 0);
            insn(0, 0, 0);
            if (e < 0) begin
                quiet("R1 no entry without enabled request", 6);
            end else begin
                watch_entry("R5 entry length", 5, (vec_base_sel ? ALT : 16'h0) + 16'((e + 1) * 2));
                if (!LVL[e]) chk(flags[e] == 0, "R3 served flag cleared", 64'(flags[e]), 0);
                src_lvl = '0; src_en = '0;
                do_return(ret_addr_in);
            end
            src_lvl = '0; src_en = '0; vec_base_sel = 0;
        end
        insn(1, 0, 0);
        flag_clr_wr = 1; flag_clr_data = '1; tick(); flag_clr_wr = 0;

        // R8 after SEI and after RETI: priority 2 over 5, with grace periods.
        src_evt = 8'h24; tick(); src_evt = '0; src_en = 8'h24;
        ret_addr_in = 22'h2A5A5A;
        insn(0, 1, 0);
        quiet("R8 no entry at sei completion", 4);
        insn(0, 0, 0);
        watch_entry("R8 entry after one instruction past sei", 5, 16'd6);
        chk(flags == 8'h20, "R3 only served flag cleared", 64'(flags), 64'h20);
        do_return(22'h2A5A5A);
        quiet("R8 no entry before an instruction after return", 3);
        ret_addr_in = 22'h01F00D;
        insn(0, 0, 0);
        watch_entry("R8 entry after one instruction past return", 5, 16'd12);
        do_return(22'h01F00D);

        // R9: disable with a request already pending.
        src_evt = 8'h01; tick(); src_evt = '0; src_en = 8'h01;
        insn(1, 0, 0);
        chk(gie == 0, "R9 gie off after disable", 64'(gie), 0);
        quiet("R9 no entry at disable", 4);
        insn(0, 0, 0);
        quiet("R9 no entry while disabled", 3);
        chk(flags[0] == 1, "R2 flag kept while blocked", 64'(flags), 1);

        // R4: a level pulse before enabling is lost.
        flag_clr_wr = 1; flag_clr_data = '1; tick(); flag_clr_wr = 0;
        src_en = '0; src_lvl = 8'h40; src_evt = 8'h40; tick(); src_lvl = '0; src_evt = '0;
        chk(flags == 0, "R4 level source sets no flag", 64'(flags), 0);
        src_en = 8'h40;
        insn(0, 1, 0); insn(0, 0, 0);
        quiet("R4 vanished level not served", 5);

        // R6: entry from sleep, alternate base.
        insn(1, 0, 0);
        src_en = '0; src_evt = 8'h08; tick(); src_evt = '0;
        insn(0, 1, 0);
        quiet("R2 disabled flag waits", 2);
        ret_addr_in = 22'h123456; vec_base_sel = 1;
        src_en = 8'h08; cpu_asleep = 1;
        tick();
        cpu_asleep = 0;
        watch_entry("R6 entry length from sleep", 10, ALT + 16'd8);
        do_return(22'h123456);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule